// File: doc/BRIEF.md
# Direct Single-Word Bus Access Unit

This unit performs one isolated transfer on an external parallel memory bus, a read or a write, without going through any FIFO. The host works through three registers. The control register holds enable, direction and start bits and reports a done flag. The address register holds the direct-mode address, kept apart from any address used by streamed transfers. The data register holds write data, and it receives the read result.

To read, the host writes the control register with enable set. It then writes enable and start together and polls done. When done is set, the data register holds the captured word. To write, the host writes enable with the direction bit set, loads the data register, then writes enable, direction and start together. For each accepted start, the unit raises one request toward the bus timing engine. It holds that request until the engine acknowledges one completed cycle.

The bus width is chosen when the cycle starts. With `wide` high the lane is 16 bits. With `wide` low it is 8 bits. Only the bits of the data register that fall inside the lane take part in the cycle.

Top module: `direct_xfer`

## Requirements
- R1: After reset, ctrl_en, done and bus_req are low, and data_q, bus_addr and bus_wdata are zero.
- R2: A control write (reg_sel 0) made while idle, with bit 0 (enable) and bit 2 (start) both set, raises bus_req on the next clock. bus_write then equals bit 1 of that write (1 = write cycle).
- R3: bus_req stays high until a clock where bus_ack is high. On the following clock bus_req is low and done is high.
- R4: When a read cycle is acknowledged, data_q is loaded on the next clock with bus_rdata zero-extended. Bits 15:0 are kept if `wide` was high when the cycle started; only bits 7:0 are kept otherwise.
- R5: bus_wdata carries data_q bits 15:0 when the latched width is wide, and data_q bits 7:0 with the upper byte zero when it is narrow. A write cycle leaves data_q unchanged.
- R6: bus_addr shows the low 6 bits of the last idle write to the address register (reg_sel 1). The data register is written with reg_sel 2.
- R7: While bus_req is high, writes to the control, address and data registers have no effect. A second start therefore launches no extra cycle.
- R8: done clears on the clock after an accepted start, and also on the clock after an idle control write with bit 0 low.
- R9: A control write with start set but enable low raises no request and leaves done low.
- R10: A bus_ack that arrives while no request is pending changes neither done nor data_q.
- R11: Start is self-clearing: each accepted start produces exactly one rising edge of bus_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data |
| reg_wdata | input | 32 | Host write value |
| wide | input | 1 | Lane width for the next cycle: 1 = 16-bit, 0 = 8-bit |
| ctrl_en | output | 1 | Enable bit of the control register |
| done | output | 1 | Completion flag |
| data_q | output | 32 | Data register contents |
| bus_req | output | 1 | Single-cycle request to the timing engine |
| bus_write | output | 1 | Direction of the requested cycle |
| bus_addr | output | 6 | Direct-mode address |
| bus_wdata | output | 16 | Write lane to the bus |
| bus_ack | input | 1 | Timing engine reports the cycle finished |
| bus_rdata | input | 16 | Data captured by the timing engine |

## Verification
An accepted control write makes bus_req and bus_write valid one clock later. An address or data write becomes visible on bus_addr, bus_wdata and data_q one clock later. An acknowledge sets done and, for a read, the new data_q one clock later. The bench's model updates its state on each rising edge from the inputs held at that edge. Every output is compared with the model at the falling edge, so each result is examined in the first cycle it is due and in every cycle after. Directed checks at the end of each scenario confirm the final data value and the number of requests issued.

// File: rtl/direct_xfer.sv
module direct_xfer #(
  parameter int REG_W    = 32,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int ADDR_W   = 6,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              wide,
  output logic              ctrl_en,
  output logic              done,
  output logic [REG_W-1:0]  data_q,
  output logic              bus_req,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [SEL_W-1:0] SEL_CTRL = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_ADDR = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_DATA = SEL_W'(2);
  localparam int B_EN = 0;
  localparam int B_WR = 1;
  localparam int B_GO = 2;
  localparam logic [DATA_W-1:0] NARROW_MASK = DATA_W'((1 << NARROW_W) - 1);

  logic busy_q, wr_q, wide_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] lane_mask;
  logic idle_we, ctrl_hit, go, finish;

  assign idle_we   = reg_we && !busy_q;
  assign ctrl_hit  = idle_we && (reg_sel == SEL_CTRL);
  assign go        = ctrl_hit && reg_wdata[B_EN] && reg_wdata[B_GO];
  assign finish    = busy_q && bus_ack;
  assign lane_mask = wide_q ? {DATA_W{1'b1}} : NARROW_MASK;

  assign bus_req   = busy_q;
  assign bus_write = wr_q;
  assign bus_addr  = addr_q;
  assign bus_wdata = data_q[DATA_W-1:0] & lane_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
      done    <= 1'b0;
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      if (ctrl_hit)
        ctrl_en <= reg_wdata[B_EN];

      if (go) begin
        busy_q <= 1'b1;
        wr_q   <= reg_wdata[B_WR];
        wide_q <= wide;
      end else if (finish) begin
        busy_q <= 1'b0;
      end

      if (go || (ctrl_hit && !reg_wdata[B_EN]))
        done <= 1'b0;
      else if (finish)
        done <= 1'b1;

      if (idle_we && reg_sel == SEL_ADDR)
        addr_q <= reg_wdata[ADDR_W-1:0];

      if (finish && !wr_q)
        data_q <= REG_W'(bus_rdata & lane_mask);
      else if (idle_we && reg_sel == SEL_DATA)
        data_q <= reg_wdata;
    end
  end
endmodule

// File: rtl/direct_xfer_chk.sv
module direct_xfer_chk #(
  parameter int REG_W    = 32,
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8,
  parameter int ADDR_W   = 6,
  parameter int SEL_W    = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [SEL_W-1:0]  reg_sel,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              done,
  input logic [REG_W-1:0]  data_q,
  input logic              bus_req,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              wide_q
);
  logic ctrl_idle;
  assign ctrl_idle = !bus_req && reg_we && (reg_sel == '0);

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle && reg_wdata[0] && reg_wdata[2] |=> bus_req && (bus_write == $past(reg_wdata[1])));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req);

  p_finish_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack |=> !bus_req && done);

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && !bus_write |=>
      data_q[NARROW_W-1:0] == $past(bus_rdata[NARROW_W-1:0]) && data_q[REG_W-1:DATA_W] == '0);

  p_narrow_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !wide_q |-> bus_wdata[DATA_W-1:NARROW_W] == '0);

  p_busy_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_write));

  p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle && reg_wdata[0] && reg_wdata[2] |=> !done);

  p_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_idle && !reg_wdata[0] |=> !bus_req && !done);

  p_stray_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && bus_ack && !reg_we |=> $stable(done) && $stable(data_q));
endmodule

bind direct_xfer direct_xfer_chk #(
  .REG_W(REG_W), .DATA_W(DATA_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .done(done), .data_q(data_q), .bus_req(bus_req), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .bus_rdata(bus_rdata), .wide_q(wide_q)
);

// File: tb/direct_xfer_bench.sv
module direct_xfer_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        wide = 1'b0;
  logic        ctrl_en, done, bus_req, bus_write;
  logic [31:0] data_q;
  logic [5:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  direct_xfer u_direct_xfer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .wide(wide), .ctrl_en(ctrl_en), .done(done), .data_q(data_q), .bus_req(bus_req),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail = 0;
  int latency = 2;
  bit stray = 1'b0;
  int req_rises = 0;
  bit prev_req = 1'b0;

  bit          m_en, m_done, m_busy, m_wr, m_wide;
  logic [5:0]  m_addr;
  logic [31:0] m_data;

  function automatic logic [15:0] m_mask();
    return m_wide ? 16'hFFFF : 16'h00FF;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial forever begin
    @(posedge clk);
    if (!rst_n) begin
      m_en = 0; m_done = 0; m_busy = 0; m_wr = 0; m_wide = 0; m_addr = '0; m_data = '0;
    end else if (m_busy) begin
      if (bus_ack) begin
        m_busy = 0;
        m_done = 1;
        if (!m_wr) m_data = {16'h0, bus_rdata & m_mask()};
      end
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: begin
          m_en = reg_wdata[0];
          if (reg_wdata[0] && reg_wdata[2]) begin
            m_busy = 1; m_done = 0; m_wr = reg_wdata[1]; m_wide = wide;
          end else if (!reg_wdata[0]) begin
            m_done = 0;
          end
        end
        2'd1: m_addr = reg_wdata[5:0];
        2'd2: m_data = reg_wdata;
        default: ;
      endcase
    end
  end

  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      check("R9 ctrl_en", 32'(ctrl_en), 32'(m_en));
      check("R3 done", 32'(done), 32'(m_done));
      check("R2 bus_req", 32'(bus_req), 32'(m_busy));
      check("R2 bus_write", 32'(bus_write), 32'(m_wr));
      check("R6 bus_addr", 32'(bus_addr), 32'(m_addr));
      check("R5 bus_wdata", 32'(bus_wdata), 32'(m_data[15:0] & m_mask()));
      check("R4 data_q", data_q, m_data);
      if (bus_req && !prev_req) req_rises++;
      prev_req = bus_req;
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      #1;
      if (stray) begin
        bus_ack = 1'b1;
      end else if (bus_req && !bus_ack) begin
        cnt++;
        if (cnt >= latency) begin
          bus_ack = 1'b1;
          cnt = 0;
        end
      end else begin
        bus_ack = 1'b0;
      end
    end
  end

  task automatic wreg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk); #1;
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && (bus_req || bus_ack); i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ctrl_en", 32'(ctrl_en), 0);
    check("R1 reset done", 32'(done), 0);
    check("R1 reset bus_req", 32'(bus_req), 0);
    check("R1 reset data_q", data_q, 0);
    check("R1 reset bus_addr", 32'(bus_addr), 0);
    check("R1 reset bus_wdata", 32'(bus_wdata), 0);
    #1 rst_n = 1'b1;

    wreg(2'd1, 32'hFFFF_FF15);
    wreg(2'd0, 32'h1);
    wide = 1'b1; bus_rdata = 16'hBEEF; latency = 3;
    wreg(2'd0, 32'h5);
    wait_idle();
    check("R4 wide read value", data_q, 32'h0000_BEEF);
    check("R3 done after read", 32'(done), 1);
    check("R6 address", 32'(bus_addr), 32'h15);

    wide = 1'b0; bus_rdata = 16'h1234; latency = 1;
    wreg(2'd0, 32'h5);
    wait_idle();
    check("R4 narrow read value", data_q, 32'h0000_0034);

    wreg(2'd0, 32'h3);
    wreg(2'd2, 32'hCAFE_5A77);
    wide = 1'b1;
    wreg(2'd0, 32'h7);
    wait_idle();
    check("R5 write keeps data", data_q, 32'hCAFE_5A77);
    check("R5 wide lane", 32'(bus_wdata), 32'h5A77);

    wide = 1'b0;
    req_rises = 0; latency = 8;
    wreg(2'd0, 32'h7);
    wreg(2'd0, 32'h5);
    wreg(2'd2, 32'h1111_1111);
    wreg(2'd1, 32'h2A);
    wait_idle();
    check("R7 R11 one request per start", 32'(req_rises), 1);
    check("R7 data write ignored while busy", data_q, 32'hCAFE_5A77);
    check("R7 addr write ignored while busy", 32'(bus_addr), 32'h15);
    check("R5 narrow lane", 32'(bus_wdata), 32'h0077);

    wreg(2'd0, 32'h4);
    check("R8 enable low clears done", 32'(done), 0);
    req_rises = 0;
    wreg(2'd0, 32'h6);
    repeat (3) @(negedge clk);
    check("R9 no request when disabled", 32'(req_rises), 0);
    check("R9 done stays low", 32'(done), 0);

    latency = 2; wide = 1'b1; bus_rdata = 16'h0F0F;
    wreg(2'd0, 32'h5);
    wait_idle();
    check("R3 done before stray ack", 32'(done), 1);
    bus_rdata = 16'hABCD;
    @(negedge clk); #1 stray = 1'b1;
    @(negedge clk); #1 stray = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 stray ack data", data_q, 32'h0000_0F0F);
    check("R10 stray ack done", 32'(done), 1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule